// File: doc/BRIEF.md
# Array Sum Co-processor

This block is a co-processor that adds up a run of 32-bit words held in memory. A host reaches it through a small command channel. Each command reads or writes one of 32 accelerator registers and gets exactly one response back, which carries the command's tag. The host first writes the base byte address of the array into register 1 and the number of words into register 2. It then writes register 0 to start the run. The value it writes there does not matter.

After the start command, the block fetches the words itself over its own memory port. It keeps only one read in flight. It waits for each returned word and adds it into a wrapping 32-bit sum. While the run is in progress, the block accepts no further host commands. A host read of register 0 therefore waits until the run ends, and then returns the sum. On the host side, register n is reached through CSR number 0x7e0 + n.

Top module: `arrsum_cop`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: Every accepted command produces one response on the following cycle. The response returns the command's `cmd_tag` on `rsp_tag` and its `cmd_write` on `rsp_write`. A write gets `rsp_rdata` = 0. A read of register n, for n from 1 to 31, returns the last value written to that register.
- R3: Register 1 holds the base byte address and register 2 holds the word count. A write to register 0 (`cmd_idx` = 0, `cmd_write` = 1) starts a run.
- R4: A run with count C issues exactly C memory reads, to addresses base + 4*i for i = 0 to C-1 in increasing order. No new read is issued until the previous read's data has been accepted.
- R5: When a run ends, a read of register 0 returns the sum of the fetched words modulo 2^32.
- R6: While a run is in progress, `cmd_ready` stays 0.
- R7: A start command with count 0 issues no memory read, and a following read of register 0 returns 0.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` does not change.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its fields stay unchanged, and `cmd_ready` is 0.
- R10: A start clears the sum, so the data written to register 0 has no effect. Repeating a run gives the same sum, not an accumulated one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_idx | input | 5 | Accelerator register number |
| cmd_wdata | input | 32 | Write data |
| cmd_tag | input | 8 | Opaque tag, echoed in the response |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_write | output | 1 | Echo of the command's write flag |
| rsp_tag | output | 8 | Echo of the command's tag |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_ready | output | 1 | Block accepts the read data |
| mem_rsp_data | input | 32 | Word returned by memory |

## Verification
The bench goes after five corner cases.

- A zero count. A design that checks the count too late would fetch one word, or about four billion words, and hang.
- A word list whose sum wraps past 2^32. A design that saturates or widens the sum would return the wrong value.
- Back-to-back runs with the same setup. A design that failed to clear the sum would return a doubled total.
- Random stalls on both memory handshakes, with addresses checked against base + 4*i. These catch a skipped or repeated word and a second read issued before the first one's data arrives.
- A host that holds off taking responses. This exposes a response overwritten while pending, and a read of register 0 that answers before the run has ended.

// File: rtl/arrsum_pkg.sv
package arrsum_pkg;
  typedef enum logic [1:0] {
    ST_CFG  = 2'd0,
    ST_RD   = 2'd1,
    ST_CALC = 2'd2
  } arrsum_st_e;
endpackage

// File: rtl/arrsum_regs.sv
module arrsum_regs #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] sum_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] cnt_o
);
  logic [DW-1:0] file_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_go
      assign file_q[g] = '0;
    end else begin : g_store
      logic [DW-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             val_q <= '0;
        else if (wr_en_i && idx_i == IW'(g))    val_q <= wdata_i;
      end
      assign file_q[g] = val_q;
    end
  end

  assign rdata_o = (idx_i == '0) ? sum_i : file_q[idx_i];
  assign base_o  = file_q[1];
  assign cnt_o   = file_q[2];
endmodule

// File: rtl/arrsum_dp.sv
module arrsum_dp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          acc_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] addr_o,
  output logic          last_o
);
  logic [DW-1:0] sum_q, idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      idx_q <= '0;
    end else if (acc_i) begin
      sum_q <= sum_q + word_i;
      idx_q <= idx_q + DW'(1);
    end
  end

  assign sum_o  = sum_q;
  assign addr_o = base_i + {idx_q[DW-3:0], 2'b00};
  assign last_o = (idx_q + DW'(1)) == cnt_i;
endmodule

// File: rtl/arrsum_ctrl.sv
module arrsum_ctrl
  import arrsum_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       cnt_zero_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  input  logic       last_i,
  output arrsum_st_e state_o,
  output logic       acc_o
);
  arrsum_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CFG:  if (go_i)        st_d = cnt_zero_i ? ST_CFG : ST_RD;
      ST_RD:   if (req_ready_i) st_d = ST_CALC;
      ST_CALC: if (rsp_valid_i) st_d = last_i ? ST_CFG : ST_RD;
      default:                  st_d = ST_CFG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_CFG;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
  assign acc_o   = (st_q == ST_CALC) && rsp_valid_i;
endmodule

// File: rtl/arrsum_cop.sv
module arrsum_cop
  import arrsum_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int TW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [IW-1:0] cmd_idx,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [TW-1:0] cmd_tag,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_write,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [DW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data
);
  arrsum_st_e    state;
  logic          cmd_fire, go, acc, last;
  logic [DW-1:0] rd_val, base, cnt, sum;
  logic          rv_q, rw_q;
  logic [TW-1:0] rt_q;
  logic [DW-1:0] rd_q;

  assign cmd_ready = (state == ST_CFG) && !rv_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign go        = cmd_fire && cmd_write && (cmd_idx == '0);

  arrsum_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (cmd_fire && cmd_write),
    .idx_i   (cmd_idx),
    .wdata_i (cmd_wdata),
    .sum_i   (sum),
    .rdata_o (rd_val),
    .base_o  (base),
    .cnt_o   (cnt)
  );

  arrsum_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .cnt_zero_i  (cnt == '0),
    .req_ready_i (mem_req_ready),
    .rsp_valid_i (mem_rsp_valid),
    .last_i      (last),
    .state_o     (state),
    .acc_o       (acc)
  );

  arrsum_dp #(.DW(DW)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (go),
    .acc_i  (acc),
    .base_i (base),
    .cnt_i  (cnt),
    .word_i (mem_rsp_data),
    .sum_o  (sum),
    .addr_o (mem_req_addr),
    .last_o (last)
  );

  // Response slot: valid flag, then payload loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rv_q <= 1'b0;
    else if (cmd_fire)  rv_q <= 1'b1;
    else if (rsp_ready) rv_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= 1'b0;
      rt_q <= '0;
      rd_q <= '0;
    end else if (cmd_fire) begin
      rw_q <= cmd_write;
      rt_q <= cmd_tag;
      rd_q <= cmd_write ? '0 : rd_val;
    end
  end

  assign rsp_valid     = rv_q;
  assign rsp_write     = rw_q;
  assign rsp_tag       = rt_q;
  assign rsp_rdata     = rd_q;
  assign mem_req_valid = (state == ST_RD);
  assign mem_rsp_ready = (state == ST_CALC);
endmodule

// File: rtl/arrsum_cop_chk.sv
module arrsum_cop_chk #(
  parameter int DW = 32,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [TW-1:0] cmd_tag,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_write,
  input logic [TW-1:0] rsp_tag,
  input logic [DW-1:0] rsp_rdata,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [DW-1:0] mem_req_addr,
  input logic          mem_rsp_ready
);
  a_r2_tag_echo: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rsp_valid && rsp_tag == $past(cmd_tag));

  a_r2_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_write |=> rsp_write && rsp_rdata == '0);

  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  a_r4_req_rsp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  a_r6_no_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready) |-> !cmd_ready);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_tag)
                                && $stable(rsp_write));

  a_r9_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
endmodule

bind arrsum_cop arrsum_cop_chk #(.DW(DW), .TW(TW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_write     (cmd_write),
  .cmd_tag       (cmd_tag),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_write     (rsp_write),
  .rsp_tag       (rsp_tag),
  .rsp_rdata     (rsp_rdata),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/arrsum_cop_tb.sv
`timescale 1ns/1ps
module arrsum_cop_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_write;
  logic [4:0]  cmd_idx;
  logic [31:0] cmd_wdata;
  logic [7:0]  cmd_tag;
  logic        rsp_valid, rsp_ready, rsp_write;
  logic [7:0]  rsp_tag;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rsp_data;

  always #4 clk = ~clk;

  arrsum_cop u_dut (.*);

  int          n_chk = 0;
  int          n_fail = 0;
  int          nreq = 0;
  logic [31:0] mem [64];
  logic [31:0] exp_base = '0;
  bit          mem_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [31:0] ref_sum(input logic [31:0] base, input int cnt);
    logic [31:0] s = '0;
    for (int i = 0; i < cnt; i++) s += mem[6'((base >> 2) + i)];
    return s;
  endfunction

  // Memory model: decisions taken at the falling edge, handshakes at the rising edge.
  initial begin
    bit          rq_fire = 0, rs_fire = 0, have = 0;
    int          dly = 0;
    logic [31:0] pdata = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rq_fire) begin
        chk(mem_req_addr == exp_base + 32'(4 * nreq), "R4 address order", mem_req_addr, exp_base + 32'(4 * nreq));
        pdata = mem[6'(mem_req_addr >> 2)];
        nreq++; have = 1; dly = $urandom % 3;
      end
      if (rs_fire) begin mem_rsp_valid = 0; have = 0; end
      if (have && !mem_rsp_valid) begin
        if (dly == 0) begin mem_rsp_valid = 1; mem_rsp_data = pdata; end
        else dly--;
      end
      if (mem_req_valid && have) chk(0, "R4 read issued while one outstanding", 1, 0);
      if ((mem_req_valid || have) && cmd_ready) chk(0, "R6 ready during run", 1, 0);
      mem_req_ready = mem_on && ($urandom % 3 != 0);
      rq_fire = mem_req_valid && mem_req_ready;
      rs_fire = mem_rsp_valid && mem_rsp_ready;
    end
  end

  task automatic xact(input bit wr, input logic [4:0] idx, input logic [31:0] wd, output logic [31:0] rd);
    logic [7:0] tg = 8'($urandom);
    int hold = $urandom % 3;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_idx = idx; cmd_wdata = wd; cmd_tag = tg;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk(rsp_valid, "R2 response follows command", 32'(rsp_valid), 1);
    rd = rsp_rdata;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == rd && !cmd_ready, "R9 response held", rsp_rdata, rd);
    end
    chk(rsp_tag == tg, "R2 tag echo", 32'(rsp_tag), 32'(tg));
    chk(rsp_write == wr, "R2 write flag echo", 32'(rsp_write), 32'(wr));
    if (wr) chk(rsp_rdata == 0, "R2 write data zero", rsp_rdata, 0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic run(input logic [31:0] base, input int cnt, input logic [31:0] gowd, output logic [31:0] s);
    logic [31:0] d;
    xact(1, 5'd1, base, d);
    xact(1, 5'd2, 32'(cnt), d);
    nreq = 0; exp_base = base;
    xact(1, 5'd0, gowd, d);
    xact(0, 5'd0, 32'h0, s);
    chk(s == ref_sum(base, cnt), "R5 sum", s, ref_sum(base, cnt));
    chk(nreq == cnt, "R4 read count", 32'(nreq), 32'(cnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, s1, s2;
    void'($urandom(32'd20251));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_idx = '0; cmd_wdata = '0; cmd_tag = '0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1, "R1 ready after reset", 32'(cmd_ready), 1);
    chk(rsp_valid == 0, "R1 no response after reset", 32'(rsp_valid), 0);
    chk(mem_req_valid == 0, "R1 no read after reset", 32'(mem_req_valid), 0);
    mem_on = 1;

    // R2: plain register storage
    xact(1, 5'd5, 32'hDEAD_BEEF, d);
    xact(1, 5'd31, 32'h1234_5678, d);
    xact(0, 5'd5, 0, d);
    chk(d == 32'hDEAD_BEEF, "R2 readback reg5", d, 32'hDEAD_BEEF);
    xact(0, 5'd31, 0, d);
    chk(d == 32'h1234_5678, "R2 readback reg31", d, 32'h1234_5678);

    // R3/R5: directed run with wrapping sum
    mem[0] = 32'd1; mem[1] = 32'd2; mem[2] = 32'd3; mem[3] = 32'hFFFF_FFFF;
    run(32'h0000_0100, 4, 32'h0, s1);
    chk(s1 == 32'd5, "R5 wrapping sum", s1, 5);
    xact(0, 5'd1, 0, d);
    chk(d == 32'h100, "R3 base register", d, 32'h100);
    xact(0, 5'd2, 0, d);
    chk(d == 32'd4, "R3 count register", d, 4);

    // R7: zero count
    run(32'h0000_0040, 0, 32'h5555_AAAA, s1);
    chk(s1 == 0, "R7 zero count sum", s1, 0);

    // R10: repeat run, different start data
    run(32'h1000_0020, 7, 32'h0, s1);
    run(32'h1000_0020, 7, 32'hFFFF_FFFF, s2);
    chk(s1 == s2, "R10 repeated run not accumulated", s2, s1);

    // Random runs, count 1 (last-on-first) included
    run(32'h0000_00FC, 1, 32'h1, s1);
    for (int r = 0; r < 25; r++) begin
      run({$urandom % 16, 20'h0, 6'($urandom), 2'b00}, $urandom % 20, $urandom, s1);
    end

    summary();
    $finish;
  end
endmodule